// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a segment reference (a segment selector, a 16-bit offset and an access type) into a physical address. In protected mode the selector picks one of eight descriptors held inside the block. Each descriptor holds a base, a last valid offset, read/write/execute rights and a presence flag. The block adds the offset to the base. It checks the reference against the descriptor and reports a single fault code whenever the reference may not proceed. A separate write port loads the descriptors.

A mode input turns the block into a fixed real-mode address generator. In that mode the selector times sixteen is the base, the 20-bit sum wraps around, and no check is made. A requester presents one reference per cycle with valid/ready. The address or fault code comes back from a register one cycle after the reference is accepted.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst` is high, `rsp_valid`, `rsp_addr` and `rsp_fault` are 0, `req_ready` is 0, and every descriptor is cleared (absent). After reset `req_ready` is 1.
- R2: A reference accepted at a clock edge (`req_valid` and `req_ready` high) sets `rsp_valid` to 1 for exactly the following cycle. In a cycle after an edge with no acceptance, `rsp_valid` is 0 and `rsp_addr` and `rsp_fault` keep their values.
- R3: In protected mode (`mode_real`=0), a reference with no fault returns `rsp_fault`=0 and `rsp_addr` = (base + offset) modulo 2^24.
- R4: A reference whose offset is greater than the descriptor's last valid offset returns fault code 2 (bounds). A last valid offset of 0 makes a one-byte segment: offset 0 passes and offset 1 faults.
- R5: The rights field encodes read in bit 0, write in bit 1 and execute in bit 2. `req_acc` is encoded as 0=read, 1=write, 2=fetch and 3=reserved. A reference whose type lacks its right, and every reserved type, returns fault code 3 (permission).
- R6: A reference to a descriptor whose presence flag is 0 returns fault code 1 (not present).
- R7: Exactly one fault code is returned. Not present outranks bounds, and bounds outranks permission.
- R8: Any faulting response drives `rsp_addr` to 0.
- R9: A descriptor write (`desc_we`) to entry `desc_idx` affects references accepted from the next edge on. A reference accepted at the same edge as the write sees the old contents.
- R10: In real mode (`mode_real`=1), `rsp_addr` = (selector*16 + offset) modulo 2^20 with bits 23:20 zero. `rsp_fault` is always 0, and the descriptor table and access type have no effect.
- R11: In protected mode only bits 2:0 of `req_seg` pick the descriptor. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_real | input | 1 | 1 selects real-mode address generation |
| req_valid | input | 1 | Reference request valid |
| req_ready | output | 1 | Block can accept a reference |
| req_seg | input | 16 | Segment selector |
| req_off | input | 16 | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 fetch) |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 3 | Descriptor entry to write |
| desc_base | input | 24 | Base address for the written entry |
| desc_limit | input | 16 | Last valid offset for the written entry |
| desc_perm | input | 3 | Rights {execute, write, read} |
| desc_present | input | 1 | Presence flag for the written entry |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 24 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 bounds, 3 permission |

## Verification
Every response is due at the first clock edge after the reference is accepted. The bench drives each reference on a falling edge and reads `rsp_valid`, `rsp_addr` and `rsp_fault` on the next falling edge, which is exactly one register stage later. A descriptor write takes effect at its own edge, so the bench places a write and a request in the same cycle and then a request in the cycle after, and checks the old and new contents at those two points. Hold behaviour is checked one further falling edge later, when no reference is accepted.

// File: rtl/seg_pkg.sv
package seg_pkg;
    parameter int unsigned SEG_ENTRIES = 8;
    parameter int unsigned IDX_W       = $clog2(SEG_ENTRIES);
    parameter int unsigned PA_W        = 24;
    parameter int unsigned OFF_W       = 16;
    parameter int unsigned SEL_W       = 16;
    parameter int unsigned REAL_SHIFT  = 4;
    parameter int unsigned REAL_W      = SEL_W + REAL_SHIFT;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_BOUNDS = 2'd2,
        FLT_PERM   = 2'd3
    } fault_e;

    typedef struct packed {
        logic             present;
        logic [2:0]       rights;   // {exec, write, read}
        logic [OFF_W-1:0] last_off;
        logic [PA_W-1:0]  base;
    } seg_desc_t;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        fault_e          fault;
    } xlate_res_t;

    function automatic logic rights_allow(logic [2:0] rights, acc_e acc);
        logic ok;
        case (acc)
            ACC_READ:  ok = rights[0];
            ACC_WRITE: ok = rights[1];
            ACC_FETCH: ok = rights[2];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_pkg::*;
#(
    parameter int unsigned ENTRIES = SEG_ENTRIES,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  seg_desc_t       wr_desc,
    input  logic [IW-1:0]   rd_idx,
    output seg_desc_t       rd_desc
);
    seg_desc_t entry_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                entry_q[g] <= wr_desc;
            end
        end
    end

    assign rd_desc = entry_q[rd_idx];
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
    import seg_pkg::*;
(
    input  seg_desc_t        desc,
    input  logic [OFF_W-1:0] offset,
    input  acc_e             acc,
    output xlate_res_t       res
);
    logic over_end;
    logic denied;

    always_comb begin
        over_end = offset > desc.last_off;
        denied   = !rights_allow(desc.rights, acc);
        res.addr  = '0;
        res.fault = FLT_NONE;
        if (!desc.present) begin
            res.fault = FLT_ABSENT;
        end else if (over_end) begin
            res.fault = FLT_BOUNDS;
        end else if (denied) begin
            res.fault = FLT_PERM;
        end else begin
            res.addr = desc.base + PA_W'(offset);
        end
    end
endmodule

// File: rtl/seg_real_gen.sv
module seg_real_gen
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0] selector,
    input  logic [OFF_W-1:0] offset,
    output xlate_res_t       res
);
    logic [REAL_W-1:0] shifted;
    logic [REAL_W-1:0] sum;

    always_comb begin
        shifted   = {selector, {REAL_SHIFT{1'b0}}};
        sum       = shifted + REAL_W'(offset);
        res.addr  = PA_W'(sum);
        res.fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_real,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic              desc_we,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [PA_W-1:0]   desc_base,
    input  logic [OFF_W-1:0]  desc_limit,
    input  logic [2:0]        desc_perm,
    input  logic              desc_present,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [1:0]        rsp_fault
);
    seg_desc_t  wr_desc;
    seg_desc_t  sel_desc;
    xlate_res_t prot_res;
    xlate_res_t real_res;
    xlate_res_t next_res;
    xlate_res_t res_q;
    logic       valid_q;
    logic       accept;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;

    always_comb begin
        wr_desc.present  = desc_present;
        wr_desc.rights   = desc_perm;
        wr_desc.last_off = desc_limit;
        wr_desc.base     = desc_base;
    end

    seg_desc_table #(.ENTRIES(SEG_ENTRIES)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (desc_we),
        .wr_idx  (desc_idx),
        .wr_desc (wr_desc),
        .rd_idx  (req_seg[IDX_W-1:0]),
        .rd_desc (sel_desc)
    );

    seg_prot_check u_check (
        .desc   (sel_desc),
        .offset (req_off),
        .acc    (acc_e'(req_acc)),
        .res    (prot_res)
    );

    seg_real_gen u_real (
        .selector (req_seg),
        .offset   (req_off),
        .res      (real_res)
    );

    assign next_res = mode_real ? real_res : prot_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                res_q <= next_res;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_addr  = res_q.addr;
    assign rsp_fault = res_q.fault;
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker
    import seg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_real,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEL_W-1:0]  req_seg,
    input logic [OFF_W-1:0]  req_off,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_addr,
    input logic [1:0]        rsp_fault
);
    localparam logic [PA_W-1:0] REAL_MASK = PA_W'((1 << REAL_W) - 1);

    p_rsp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_no_rsp_without_accept_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> ($stable(rsp_addr) && $stable(rsp_fault)));

    p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0));

    p_real_no_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && mode_real) |=> (rsp_fault == 2'd0));

    p_real_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && mode_real) |=>
        (rsp_addr == ((PA_W'($past(req_seg)) * PA_W'(16) + PA_W'($past(req_off))) & REAL_MASK)));

    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready);
endmodule

bind seg_xlate_unit seg_xlate_checker u_chk (.*);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_real;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_seg;
    logic [15:0] req_off;
    logic [1:0]  req_acc;
    logic        desc_we;
    logic [2:0]  desc_idx;
    logic [23:0] desc_base;
    logic [15:0] desc_limit;
    logic [2:0]  desc_perm;
    logic        desc_present;
    logic        rsp_valid;
    logic [23:0] rsp_addr;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    seg_xlate_unit dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
        desc_we = 0; desc_idx = 0; desc_base = 0; desc_limit = 0;
        desc_perm = 0; desc_present = 0;
    endtask

    task automatic write_desc(logic [2:0] idx, logic [23:0] base, logic [15:0] lim,
                              logic [2:0] perm, logic pres);
        desc_we = 1; desc_idx = idx; desc_base = base; desc_limit = lim;
        desc_perm = perm; desc_present = pres;
        @(negedge clk);
        desc_we = 0;
    endtask

    task automatic request(string tag, logic [15:0] seg, logic [15:0] off, logic [1:0] acc,
                           logic [23:0] exp_addr, logic [1:0] exp_fault);
        req_valid = 1; req_seg = seg; req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " addr"}, 32'(rsp_addr), 32'(exp_addr));
        chk({tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(rsp_valid), 0);
        chk("R1 addr", 32'(rsp_addr), 0);
        chk("R1 fault", 32'(rsp_fault), 0);
        chk("R1 ready low", 32'(req_ready), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 ready high", 32'(req_ready), 1);
        // cleared table: entry 6 absent
        request("R1 cleared entry", 16'd6, 16'd0, 2'd0, 24'h0, 2'd1);
    endtask

    task automatic t_load();
        write_desc(3'd0, 24'h123400, 16'h00FF, 3'b011, 1'b1);
        write_desc(3'd1, 24'hFFFFF0, 16'hFFFF, 3'b100, 1'b1);
        write_desc(3'd2, 24'h000800, 16'h0000, 3'b001, 1'b1);
        write_desc(3'd3, 24'h005000, 16'h0010, 3'b000, 1'b0);
        write_desc(3'd4, 24'h007000, 16'h0010, 3'b000, 1'b1);
    endtask

    task automatic t_translate();
        request("R3 read", 16'd0, 16'h0010, 2'd0, 24'h123410, 2'd0);
        request("R3 write at last offset", 16'd0, 16'h00FF, 2'd1, 24'h1234FF, 2'd0);
        request("R3 wrap 2^24", 16'd1, 16'h0020, 2'd2, 24'h000010, 2'd0);
    endtask

    task automatic t_hold();
        request("R2 resp", 16'd0, 16'h0020, 2'd0, 24'h123420, 2'd0);
        @(negedge clk);
        chk("R2 valid drops", 32'(rsp_valid), 0);
        chk("R2 addr held", 32'(rsp_addr), 32'h123420);
        chk("R2 fault held", 32'(rsp_fault), 0);
    endtask

    task automatic t_bounds();
        request("R4 past end", 16'd0, 16'h0100, 2'd0, 24'h0, 2'd2);
        request("R4 one byte ok", 16'd2, 16'h0000, 2'd0, 24'h000800, 2'd0);
        request("R4 one byte over", 16'd2, 16'h0001, 2'd0, 24'h0, 2'd2);
    endtask

    task automatic t_perm();
        request("R5 read on exec-only", 16'd1, 16'h0000, 2'd0, 24'h0, 2'd3);
        request("R5 write on exec-only", 16'd1, 16'h0000, 2'd1, 24'h0, 2'd3);
        request("R5 fetch on rw", 16'd0, 16'h0000, 2'd2, 24'h0, 2'd3);
        request("R5 reserved type", 16'd0, 16'h0000, 2'd3, 24'h0, 2'd3);
        request("R8 fault addr zero", 16'd2, 16'h0000, 2'd1, 24'h0, 2'd3);
    endtask

    task automatic t_absent_priority();
        request("R6 absent", 16'd3, 16'h0000, 2'd0, 24'h0, 2'd1);
        request("R7 absent over bounds", 16'd3, 16'h0020, 2'd1, 24'h0, 2'd1);
        request("R7 bounds over perm", 16'd4, 16'h0020, 2'd0, 24'h0, 2'd2);
        request("R7 perm alone", 16'd4, 16'h0000, 2'd0, 24'h0, 2'd3);
    endtask

    task automatic t_write_timing();
        // same edge: write entry 5 present while requesting it
        desc_we = 1; desc_idx = 3'd5; desc_base = 24'h0A0000; desc_limit = 16'h0FFF;
        desc_perm = 3'b111; desc_present = 1;
        request("R9 same-cycle sees old", 16'd5, 16'h0004, 2'd0, 24'h0, 2'd1);
        desc_we = 0;
        request("R9 next-cycle sees new", 16'd5, 16'h0004, 2'd0, 24'h0A0004, 2'd0);
    endtask

    task automatic t_index_bits();
        request("R11 upper selector bits ignored", 16'hFF80, 16'h0010, 2'd0, 24'h123410, 2'd0);
        request("R11 upper bits on entry 2", 16'h0AAA, 16'h0000, 2'd0, 24'h000800, 2'd0);
    endtask

    task automatic t_real();
        mode_real = 1;
        request("R10 basic", 16'h1234, 16'h0010, 2'd0, 24'h012350, 2'd0);
        request("R10 wrap to zero", 16'hFFFF, 16'h0010, 2'd0, 24'h000000, 2'd0);
        request("R10 wrap high", 16'hFFFF, 16'hFFFF, 2'd2, 24'h00FFEF, 2'd0);
        request("R10 table ignored", 16'h0003, 16'h0005, 2'd3, 24'h000035, 2'd0);
        mode_real = 0;
        request("R10 back to protected", 16'd0, 16'h0001, 2'd0, 24'h123401, 2'd0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; mode_real = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        t_load();
        t_translate();
        t_hold();
        t_bounds();
        t_perm();
        t_absent_priority();
        t_write_timing();
        t_index_bits();
        t_real();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule